// File: doc/BRIEF.md
# Debug Test Access Port with Compute-Cell Register Probe

This block is a serial debug port that runs entirely on its own test clock, which has no phase or frequency relation to the compute clock. A standard 16-state controller is steered by the mode-select line. It selects either a 3-bit instruction register or one of four data registers: a 1-bit bypass stage, a 32-bit identification word, a boundary register over a group of pins, and a probe register. The probe register captures the internal state of one compute cell.

The compute domain presents each cell's internal registers on a flat snapshot bus. Inside the port, a synchronizer chain re-times that bus to the test clock. The probe instruction then captures one cell's slice, chosen by a small select register. The select register is written through the same probe shift, so a single scan both reads the current cell and picks the next one. There is no dedicated test reset pin. The port is reset by a power-on reset, or by holding the mode-select line high for five test-clock cycles.

Top module: `jtag_probe_tap`

## Requirements
- R1: After power-on reset, and after any five consecutive rising test-clock edges with `tms` high (from any state), the controller is in Test-Logic-Reset and the active instruction is the identification instruction (opcode 3'b001).
- R2: With the identification instruction active, a data scan shifts out 32'h1BEEF0D7, least significant bit first, on `tdo`.
- R3: Every instruction scan first shifts out the captured pattern 3'b001, least significant bit first. The bits shifted in on `tdi` (least significant bit first) become the active instruction when Update-IR is left.
- R4: Opcode 3'b111, and the unassigned opcodes 3'b100, 3'b101 and 3'b110, select a 1-bit bypass stage that captures 0. Each data bit therefore appears on `tdo` one shift later.
- R5: Opcode 3'b010 (sample/preload) captures `pin_in` into the boundary register and shifts it out least significant bit first. `pin_out` keeps following `core_out`. Update-DR loads the shifted-in word into the boundary update latch.
- R6: Opcode 3'b000 (external test) drives `pin_out` from the boundary update latch. This includes a value preloaded earlier under opcode 3'b010. Update-DR under 3'b000 replaces that value with the newly shifted word. Under every other opcode, `pin_out` equals `core_out`.
- R7: Opcode 3'b011 (probe) captures the 16-bit slice `snap_bus[16*k +: 16]` of cell k, where k is the select register, least significant bit first. The select register is 0 after reset. Update-DR under 3'b011 loads k from bits [15:14] of the shifted-in word. A data scan under any other opcode leaves k unchanged.
- R8: `tdo_en` is high only in Shift-IR and Shift-DR. `tdo` changes only on the falling edge of `tck`, and is 0 while `tdo_en` is low.
- R9: Once a value on `snap_bus` has been stable for more than two test-clock cycles before a Capture-DR, that value is what the probe captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| tms | input | 1 | Mode select, sampled on the rising edge of `tck` |
| tdi | input | 1 | Serial data in, sampled on the rising edge of `tck` |
| tdo | output | 1 | Serial data out, updated on the falling edge of `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| pin_in | input | 8 | Pin levels observed by the boundary register |
| core_out | input | 8 | Functional values the core wants to drive on the pins |
| pin_out | output | 8 | Pin drive: `core_out`, or the boundary latch under external test |
| snap_bus | input | 64 | Four 16-bit cell snapshots from the compute domain, cell 0 in the low bits |

## Verification
A corrupt controller state shows within one test-clock cycle as `tdo_en` asserted, or dropped, outside the shift states. A wrong instruction register shows on the very next data scan: the word shifted out has the wrong length or contents. A wrong cell select stays hidden until the following probe capture, where it returns the slice of a different cell. A missing or late boundary update shows as `pin_out` failing to follow the latch as soon as Update-DR has completed.

// File: rtl/jtag_probe_pkg.sv
package jtag_probe_pkg;

   localparam int IR_W = 3;

   localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
   localparam logic [IR_W-1:0] OP_PROBE   = 3'b011;
   localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      DR_BYPASS, DR_IDENT, DR_BOUND, DR_PROBE
   } dr_sel_e;

   // Opcodes without an assignment fall back to the bypass stage.
   function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] op);
      case (op)
         OP_IDCODE:            return DR_IDENT;
         OP_EXTEST, OP_SAMPLE: return DR_BOUND;
         OP_PROBE:             return DR_PROBE;
         default:              return DR_BYPASS;
      endcase
   endfunction

endpackage

// File: rtl/jtag_probe_fsm.sv
module jtag_probe_fsm
   import jtag_probe_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
         ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
         ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= ST_TLR;
      else        state <= nxt;
   end

   // Counts consecutive rising edges with tms high, saturating at five.
   logic [2:0] tms_hi_cnt;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                 tms_hi_cnt <= 3'd0;
      else if (!tms)              tms_hi_cnt <= 3'd0;
      else if (tms_hi_cnt != 3'd5) tms_hi_cnt <= tms_hi_cnt + 3'd1;
   end

   // R1: five rising edges with tms high always land in Test-Logic-Reset
   a_r1_tms_reset: assert property (@(posedge tck) disable iff (!por_n)
      (tms_hi_cnt == 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/jtag_probe_ir.sv
module jtag_probe_ir
   import jtag_probe_pkg::*;
(
   input  logic            tck,
   input  logic            por_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir,
   output logic            ir_lsb
);

   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sr <= IR_CAPTURE;
      end else if (state == ST_CAP_IR) begin
         ir_sr <= IR_CAPTURE;
      end else if (state == ST_SH_IR) begin
         ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                  ir <= OP_IDCODE;
      else if (state == ST_TLR)    ir <= OP_IDCODE;
      else if (state == ST_UPD_IR) ir <= ir_sr;
   end

   assign ir_lsb = ir_sr[0];

   // R1: Test-Logic-Reset leaves the identification instruction active
   a_r1_ir_ident: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_TLR) |=> (ir == OP_IDCODE));

   // R3: the active instruction only changes when leaving Update-IR or reset
   a_r3_ir_hold: assert property (@(posedge tck) disable iff (!por_n)
      (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir));

endmodule

// File: rtl/jtag_probe_sync.sv
module jtag_probe_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         tck,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      if (STAGES < 2) $error("jtag_probe_sync: STAGES must be at least 2");
      if (W < 1)      $error("jtag_probe_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge tck or negedge por_n) begin
            if (!por_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge tck or negedge por_n) begin
            if (!por_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/jtag_probe_dr.sv
module jtag_probe_dr
   import jtag_probe_pkg::*;
#(
   parameter logic [31:0] ID_WORD = 32'h1BEEF0D7,
   parameter int          BSR_W   = 8,
   parameter int          CELLS   = 4,
   parameter int          SNAP_W  = 16,
   localparam int         SEL_W   = $clog2(CELLS)
) (
   input  logic                    tck,
   input  logic                    por_n,
   input  tap_state_e              state,
   input  logic [IR_W-1:0]         ir,
   input  logic                    tdi,
   input  logic [BSR_W-1:0]        pin_in,
   input  logic [CELLS*SNAP_W-1:0] snap,
   output logic                    dr_lsb,
   output logic [BSR_W-1:0]        bsr_upd,
   output logic [SEL_W-1:0]        sel
);

   initial begin
      if (ID_WORD[0] != 1'b1)     $error("jtag_probe_dr: identification word needs bit 0 set");
      if (CELLS < 2 || (CELLS & (CELLS - 1)) != 0)
                                  $error("jtag_probe_dr: CELLS must be a power of two >= 2");
      if (SNAP_W < SEL_W)         $error("jtag_probe_dr: SNAP_W narrower than select field");
      if (BSR_W < 1)              $error("jtag_probe_dr: BSR_W must be positive");
   end

   dr_sel_e kind;
   assign kind = decode_dr(ir);

   logic              byp_sr;
   logic [31:0]       id_sr;
   logic [BSR_W-1:0]  bsr_sr;
   logic [SNAP_W-1:0] prb_sr;
   logic [SNAP_W-1:0] cell_slice;

   assign cell_slice = snap[sel*SNAP_W +: SNAP_W];

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         byp_sr <= 1'b0;
         id_sr  <= '0;
         bsr_sr <= '0;
         prb_sr <= '0;
      end else if (state == ST_CAP_DR) begin
         case (kind)
            DR_IDENT: id_sr  <= ID_WORD;
            DR_BOUND: bsr_sr <= pin_in;
            DR_PROBE: prb_sr <= cell_slice;
            default:  byp_sr <= 1'b0;
         endcase
      end else if (state == ST_SH_DR) begin
         case (kind)
            DR_IDENT: id_sr  <= {tdi, id_sr[31:1]};
            DR_BOUND: bsr_sr <= {tdi, bsr_sr[BSR_W-1:1]};
            DR_PROBE: prb_sr <= {tdi, prb_sr[SNAP_W-1:1]};
            default:  byp_sr <= tdi;
         endcase
      end
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         bsr_upd <= '0;
         sel     <= '0;
      end else if (state == ST_UPD_DR) begin
         if (kind == DR_BOUND) bsr_upd <= bsr_sr;
         if (kind == DR_PROBE) sel     <= prb_sr[SNAP_W-1 -: SEL_W];
      end
   end

   always_comb begin
      case (kind)
         DR_IDENT: dr_lsb = id_sr[0];
         DR_BOUND: dr_lsb = bsr_sr[0];
         DR_PROBE: dr_lsb = prb_sr[0];
         default:  dr_lsb = byp_sr;
      endcase
   end

   // R7: the cell select moves only on Update-DR under the probe opcode
   a_r7_sel_hold: assert property (@(posedge tck) disable iff (!por_n)
      !(state == ST_UPD_DR && ir == OP_PROBE) |=> $stable(sel));

   // R5: the boundary latch moves only on Update-DR under a boundary opcode
   a_r5_bsr_hold: assert property (@(posedge tck) disable iff (!por_n)
      !(state == ST_UPD_DR && (ir == OP_EXTEST || ir == OP_SAMPLE)) |=> $stable(bsr_upd));

endmodule

// File: rtl/jtag_probe_tap.sv
module jtag_probe_tap
   import jtag_probe_pkg::*;
#(
   parameter logic [31:0] ID_WORD     = 32'h1BEEF0D7,
   parameter int          BSR_W       = 8,
   parameter int          CELLS       = 4,
   parameter int          SNAP_W      = 16,
   parameter int          SYNC_STAGES = 2,
   localparam int         SEL_W       = $clog2(CELLS),
   localparam int         BUS_W       = CELLS * SNAP_W
) (
   input  logic             tck,
   input  logic             por_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_en,
   input  logic [BSR_W-1:0] pin_in,
   input  logic [BSR_W-1:0] core_out,
   output logic [BSR_W-1:0] pin_out,
   input  logic [BUS_W-1:0] snap_bus
);

   tap_state_e       state;
   logic [IR_W-1:0]  ir;
   logic             ir_lsb;
   logic             dr_lsb;
   logic [BSR_W-1:0] bsr_upd;
   logic [SEL_W-1:0] sel;
   logic [BUS_W-1:0] snap_t;

   jtag_probe_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   jtag_probe_ir u_ir (
      .tck    (tck),
      .por_n  (por_n),
      .state  (state),
      .tdi    (tdi),
      .ir     (ir),
      .ir_lsb (ir_lsb)
   );

   jtag_probe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .tck   (tck),
      .por_n (por_n),
      .d     (snap_bus),
      .q     (snap_t)
   );

   jtag_probe_dr #(
      .ID_WORD (ID_WORD),
      .BSR_W   (BSR_W),
      .CELLS   (CELLS),
      .SNAP_W  (SNAP_W)
   ) u_dr (
      .tck     (tck),
      .por_n   (por_n),
      .state   (state),
      .ir      (ir),
      .tdi     (tdi),
      .pin_in  (pin_in),
      .snap    (snap_t),
      .dr_lsb  (dr_lsb),
      .bsr_upd (bsr_upd),
      .sel     (sel)
   );

   // Output stage re-timed to the falling edge.
   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
         tdo    <= (state == ST_SH_IR) ? ir_lsb :
                   (state == ST_SH_DR) ? dr_lsb : 1'b0;
      end
   end

   assign pin_out = (ir == OP_EXTEST) ? bsr_upd : core_out;

   // R8: the output enable is seen only while the controller shifts
   a_r8_tdo_en_shift: assert property (@(posedge tck) disable iff (!por_n)
      tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

   // R8: tdo is quiet while not enabled
   a_r8_tdo_quiet: assert property (@(posedge tck) disable iff (!por_n)
      !tdo_en |-> !tdo);

endmodule

// File: tb/jtag_probe_tap_test.sv
module jtag_probe_tap_test;
   localparam int TCK_PERIOD = 20;
   localparam logic [31:0] ID = 32'h1BEEF0D7;

   logic        tck = 1'b0;
   logic        por_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo, tdo_en;
   logic [7:0]  pin_in = 8'h00;
   logic [7:0]  core_out = 8'hC3;
   logic [7:0]  pin_out;
   logic [63:0] snap_bus = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   bit q_exp[$];
   bit q_care[$];
   int q_req[$];

   jtag_probe_tap uut (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .pin_in(pin_in), .core_out(core_out), .pin_out(pin_out), .snap_bus(snap_bus)
   );

   always #(TCK_PERIOD/2) tck = ~tck;

   task automatic check(input bit ok, input int req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: every shift cycle pops one expected item.
   always @(posedge tck) begin
      if (por_n && tdo_en) begin
         if (q_exp.size() == 0) begin
            check(1'b0, 8, 64'(tdo), 64'h0);
         end else begin
            automatic bit e = q_exp.pop_front();
            automatic bit c = q_care.pop_front();
            automatic int r = q_req.pop_front();
            if (c) check(tdo === e, r, 64'(tdo), 64'(e));
         end
      end
   end

   task automatic step(input bit t, input bit d);
      @(negedge tck);
      tms <= t;
      tdi <= d;
   endtask

   task automatic push(input bit e, input bit c, input int r);
      q_exp.push_back(e);
      q_care.push_back(c);
      q_req.push_back(r);
   endtask

   task automatic settle();
      @(negedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic go_reset();
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   // From Run-Test/Idle back to Run-Test/Idle; capture pattern checked (R3).
   task automatic scan_ir(input logic [2:0] op);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      push(1'b1, 1'b1, 3); push(1'b0, 1'b1, 3); push(1'b0, 1'b1, 3);
      for (int i = 0; i < 3; i++) step(i == 2, op[i]);
      step(1, 0); step(0, 0);
   endtask

   task automatic scan_dr(input int len, input logic [63:0] din, input logic [63:0] dexp,
                          input bit care, input int req);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < len; i++) push(dexp[i], care, req);
      for (int i = 0; i < len; i++) step(i == len - 1, din[i]);
      step(1, 0); step(0, 0);
   endtask

   initial begin
      #(TCK_PERIOD * 100000);
      if (!done) begin
         check(1'b0, 1, 64'h0, 64'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      snap_bus = {16'h7081, 16'h5E6F, 16'h3C4D, 16'hA1B2};
      repeat (3) @(negedge tck);
      #1;
      // R8 / R6: reset state
      check(tdo_en == 1'b0, 8, 64'(tdo_en), 64'h0);
      check(pin_out == core_out, 6, 64'(pin_out), 64'(core_out));
      por_n = 1'b1;
      step(0, 0);
      settle();
      check(tdo_en == 1'b0 && tdo == 1'b0, 8, {tdo_en, tdo}, 64'h0);

      // R1, R2: identification word is active after power-on reset
      scan_dr(32, 64'h0, 64'(ID), 1'b1, 2);

      // R4: bypass opcode, then unassigned opcodes
      scan_ir(3'b111);
      scan_dr(8, 64'hA5, {55'h0, 8'hA5, 1'b0}, 1'b1, 4);
      scan_ir(3'b101);
      scan_dr(6, 64'h2D, {57'h0, 6'h2D, 1'b0}, 1'b1, 4);
      scan_ir(3'b100);
      scan_dr(4, 64'h9, {59'h0, 4'h9, 1'b0}, 1'b1, 4);

      // R5: sample/preload captures pins and leaves pin_out on the core
      pin_in = 8'h3C;
      scan_ir(3'b010);
      scan_dr(8, 64'h5A, 64'h3C, 1'b1, 5);
      settle();
      check(pin_out == core_out, 5, 64'(pin_out), 64'(core_out));

      // R6: external test drives the preloaded value, then the new one
      scan_ir(3'b000);
      settle();
      check(pin_out == 8'h5A, 6, 64'(pin_out), 64'h5A);
      pin_in = 8'hE1;
      scan_dr(8, 64'h96, 64'hE1, 1'b1, 5);
      settle();
      check(pin_out == 8'h96, 6, 64'(pin_out), 64'h96);

      // R7: probe of cell 0, then reselect through the shifted word
      scan_ir(3'b011);
      settle();
      check(pin_out == core_out, 6, 64'(pin_out), 64'(core_out));
      scan_dr(16, 64'h8000, 64'hA1B2, 1'b1, 7);
      scan_dr(16, 64'h4000, 64'h5E6F, 1'b1, 7);
      scan_dr(16, 64'hC000, 64'h3C4D, 1'b1, 7);
      scan_dr(16, 64'h0000, 64'h7081, 1'b1, 7);
      // R7: other opcodes leave the select alone (select is now 0)
      scan_dr(16, 64'hC000, 64'hA1B2, 1'b1, 7);
      scan_ir(3'b111);
      scan_dr(16, 64'h4000, {47'h0, 16'h4000, 1'b0}, 1'b1, 4);
      scan_ir(3'b011);
      scan_dr(16, 64'h0000, 64'h7081, 1'b1, 7);

      // R9: a new snapshot for cell 0 is visible after it settles
      snap_bus[15:0] = 16'hBEAD;
      repeat (4) @(negedge tck);
      scan_dr(16, 64'h0000, 64'hBEAD, 1'b1, 9);

      // R1: five tms-high edges from the middle of a data shift
      step(1, 0); step(0, 0); step(0, 0);
      push(1'b0, 1'b0, 1);
      for (int i = 0; i < 5; i++) step(1, 0);
      step(0, 0);
      settle();
      check(tdo_en == 1'b0, 8, 64'(tdo_en), 64'h0);
      scan_dr(32, 64'h0, 64'(ID), 1'b1, 1);

      // R1: power-on reset again returns to the identification word
      scan_ir(3'b010);
      por_n = 1'b0;
      #(TCK_PERIOD);
      por_n = 1'b1;
      step(0, 0);
      scan_dr(32, 64'h0, 64'(ID), 1'b1, 1);

      settle();
      check(q_exp.size() == 0, 8, 64'(q_exp.size()), 64'h0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule